// File: doc/BRIEF.md
# Packed RGB Small-Float Expander

The block accepts one 32-bit word that carries three unsigned small floating-point values: red and green with a 5-bit exponent and a 6-bit mantissa, and blue with a 5-bit exponent and a 5-bit mantissa. It expands each value into an IEEE-754 single-precision word. A fourth output always carries 1.0 for alpha. The block sits in a texture or colour-buffer read path, where packed colours are widened for the shading datapath.

All three channels use an exponent bias of 15 and an implied leading one for normal values. An exponent of zero marks a denormal or zero. A denormal is never flushed: a leading-one detector normalises it into an exact single-precision normal. An all-ones exponent marks infinity or NaN. It becomes the single-precision all-ones exponent, and the mantissa is carried into the top bits of the 23-bit fraction. None of the source formats has a sign, so every result is non-negative.

The result is registered. Output valid follows input valid exactly one cycle later. While input valid is low, the data outputs keep their last value.

Top module: `rgb_pf_expand`

## Requirements
- R1: While reset is asserted and in the first cycle after it, out_valid is 0.
- R2: out_valid is high in a cycle exactly when in_valid was high in the previous cycle, so back-to-back inputs give back-to-back results in order.
- R3: Field positions are fixed. Red is in_word[10:0], green is in_word[21:11] and blue is in_word[31:22]. In each field the mantissa is the low bits (6, 6 and 5 bits) and the 5-bit exponent sits directly above it. A value in one field never affects another channel's output.
- R4: A field with an exponent e from 1 to 30 gives single-precision exponent e+112. Its mantissa is left-aligned in bits [22:0] and the remaining low bits are zero.
- R5: A field with exponent 0 and a non-zero mantissa m of width M gives the exact single-precision normal of m·2^(-14-M). With the leading one of m at position p, the exponent is p-M+113.
- R6: A field of all zeros gives +0.0 (0x00000000).
- R7: A field with exponent 31 gives single-precision exponent 255 with the mantissa left-aligned in the fraction, so infinity maps to 0x7F800000 and NaN stays NaN.
- R8: out_alpha is always 0x3F800000.
- R9: Bit 31 of out_red, out_green and out_blue is always 0.
- R10: In a cycle after one with in_valid low, out_red, out_green and out_blue keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | in_word holds a packed colour this cycle |
| in_word | input | 32 | Packed blue/green/red small floats |
| out_valid | output | 1 | Outputs hold a converted colour |
| out_red | output | 32 | Red as single precision |
| out_green | output | 32 | Green as single precision |
| out_blue | output | 32 | Blue as single precision |
| out_alpha | output | 32 | Constant 1.0 |

## Verification
The hardest paths to reach are denormals whose leading one sits at each position of the mantissa, because every position takes a different shift and exponent. The stimulus drives these directly: the single lowest mantissa bit, the full mantissa, and a denormal with only its top bit set. Each channel has a different class in the same word, which exposes swapped or overlapping fields. A long back-to-back stream of pseudo-random words then reaches normals, infinities and NaNs in every channel while the one-cycle ordering is checked by the scoreboard.

// File: rtl/sfx_pkg.sv
package sfx_pkg;

  localparam int          F32_W    = 32;
  localparam int          F32_MAN  = 23;
  localparam int          F32_BIAS = 127;
  localparam logic [31:0] F32_ONE  = 32'h3F80_0000;

  // Rebias a normal small exponent into the single-precision range.
  function automatic logic [7:0] norm_exp(input logic [7:0] small_e, input int bias);
    return 8'(int'(small_e) + F32_BIAS - bias);
  endfunction

  // Exponent of a normalised denormal whose leading one is at bit 'lead'.
  // value = m * 2^(1 - bias - mw); leading one lifts it by 'lead'.
  function automatic logic [7:0] denorm_exp(input int lead, input int mw, input int bias);
    return 8'(lead - mw + 1 - bias + F32_BIAS);
  endfunction

  // Left-align an mw-bit fraction into the 23-bit single-precision fraction.
  function automatic logic [22:0] align_frac(input logic [22:0] m, input int mw);
    return m << (F32_MAN - mw);
  endfunction

endpackage

// File: rtl/sfx_lead_one.sv
module sfx_lead_one #(
  parameter int W  = 6,
  localparam int PW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec_i,
  output logic [PW-1:0] pos_o,
  output logic          any_o
);

  // Highest set bit wins: later iterations overwrite earlier ones.
  always_comb begin
    pos_o = '0;
    any_o = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) begin
        pos_o = PW'(i);
        any_o = 1'b1;
      end
    end
  end

endmodule

// File: rtl/sfx_field_decode.sv
module sfx_field_decode #(
  parameter int MW = 6,
  parameter int EW = 5,
  localparam int FW   = MW + EW,
  localparam int BIAS = (1 << (EW - 1)) - 1,
  localparam int PW   = (MW > 1) ? $clog2(MW) : 1
) (
  input  logic [FW-1:0] fld_i,
  output logic [31:0]   flt_o,
  output logic          zero_o,
  output logic          denorm_o,
  output logic          special_o
);
  import sfx_pkg::*;

  logic [MW-1:0] man;
  logic [EW-1:0] sexp;
  logic          exp_zero;
  logic          exp_max;
  logic [PW-1:0] lead_pos;
  logic          man_nz;
  logic [MW-1:0] man_hidden_cleared;
  logic [22:0]   frac_denorm;
  logic [22:0]   frac_plain;

  assign man      = fld_i[MW-1:0];
  assign sexp     = fld_i[FW-1:MW];
  assign exp_zero = (sexp == '0);
  assign exp_max  = &sexp;

  sfx_lead_one #(.W(MW)) u_lead (
    .vec_i (man),
    .pos_o (lead_pos),
    .any_o (man_nz)
  );

  // Events brought out for the checks in the top module.
  assign zero_o    = exp_zero && !man_nz;
  assign denorm_o  = exp_zero && man_nz;
  assign special_o = exp_max;

  always_comb begin
    man_hidden_cleared = man & ~({{(MW-1){1'b0}}, 1'b1} << lead_pos);
    frac_denorm        = 23'(man_hidden_cleared) << (F32_MAN - int'(lead_pos));
    frac_plain         = align_frac(23'(man), MW);
  end

  always_comb begin
    if (zero_o) begin
      flt_o = '0;
    end else if (denorm_o) begin
      flt_o = {1'b0, denorm_exp(int'(lead_pos), MW, BIAS), frac_denorm};
    end else if (exp_max) begin
      flt_o = {1'b0, 8'hFF, frac_plain};
    end else begin
      flt_o = {1'b0, norm_exp(8'(sexp), BIAS), frac_plain};
    end
  end

endmodule

// File: rtl/rgb_pf_expand.sv
module rgb_pf_expand #(
  parameter int EXP_W  = 5,
  parameter int RED_MW = 6,
  parameter int GRN_MW = 6,
  parameter int BLU_MW = 5,
  localparam int WORD_W = RED_MW + GRN_MW + BLU_MW + 3 * EXP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  output logic              out_valid,
  output logic [31:0]       out_red,
  output logic [31:0]       out_green,
  output logic [31:0]       out_blue,
  output logic [31:0]       out_alpha
);
  import sfx_pkg::*;

  localparam int NCH  = 3;
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam int MW_A [NCH] = '{RED_MW, GRN_MW, BLU_MW};
  localparam int LO_A [NCH] = '{0, RED_MW + EXP_W, RED_MW + GRN_MW + 2 * EXP_W};

  logic [31:0]    dec [NCH];
  logic [NCH-1:0] zro;
  logic [NCH-1:0] den;
  logic [NCH-1:0] spc;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int FW = MW_A[c] + EXP_W;

    sfx_field_decode #(.MW(MW_A[c]), .EW(EXP_W)) u_fld (
      .fld_i     (in_word[LO_A[c] +: FW]),
      .flt_o     (dec[c]),
      .zero_o    (zro[c]),
      .denorm_o  (den[c]),
      .special_o (spc[c])
    );

    // R5: a normalised denormal lands inside the exponent window its width allows
    assert_denorm_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
      den[c] |-> (dec[c][30:23] >= denorm_exp(0, MW_A[c], BIAS)) &&
                 (dec[c][30:23] <= denorm_exp(MW_A[c] - 1, MW_A[c], BIAS)));

    // R7: every special field leaves with the widened all-ones exponent
    assert_special_exp_R7: assert property (@(posedge clk) disable iff (!rst_n)
      spc[c] |-> dec[c][30:23] == 8'hFF);

    // R6: an all-zero field yields positive zero
    assert_zero_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
      zro[c] |-> dec[c] == 32'h0);

    // R4: classes are exclusive, so a field is decoded by one path only
    assert_one_class_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({zro[c], den[c], spc[c]}));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_red   <= '0;
      out_green <= '0;
      out_blue  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_red   <= dec[0];
        out_green <= dec[1];
        out_blue  <= dec[2];
      end
    end
  end

  assign out_alpha = F32_ONE;

  // R2: result valid tracks input valid one cycle later
  assert_valid_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R10: idle cycles leave the colour outputs untouched
  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_red) && $stable(out_green) && $stable(out_blue));

  // R9: no result ever carries a sign
  assert_sign_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_red[31] && !out_green[31] && !out_blue[31]);

endmodule

// File: tb/rgb_pf_expand_bench.sv
module rgb_pf_expand_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_word = '0;
  logic        out_valid;
  logic [31:0] out_red, out_green, out_blue, out_alpha;

  int n_checks = 0;
  int n_fail   = 0;
  int n_sent   = 0;
  int n_recv   = 0;
  bit done     = 1'b0;

  logic [95:0] exp_q [$];
  string       tag_q [$];
  logic [95:0] last_exp = '0;

  always #10 clk = ~clk;

  rgb_pf_expand u_rgb_pf_expand (
    .clk, .rst_n, .in_valid, .in_word,
    .out_valid, .out_red, .out_green, .out_blue, .out_alpha
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, expv);
    end
  endtask

  // Reference: value = m * 2^(-14-mw) for e==0, else hidden one and e-15.
  function automatic logic [31:0] ref_fld(input int v, input int mw);
    int e, m, mm, ee;
    e = v >> mw;
    m = v & ((1 << mw) - 1);
    if (e == 31) return {1'b0, 8'hFF, 23'(m << (23 - mw))};
    if (e != 0)  return {1'b0, 8'(e + 112), 23'(m << (23 - mw))};
    if (m == 0)  return 32'h0;
    mm = m;
    ee = -14;
    while (mm < (1 << mw)) begin
      mm = mm * 2;
      ee = ee - 1;
    end
    return {1'b0, 8'(ee + 127), 23'((mm - (1 << mw)) << (23 - mw))};
  endfunction

  task automatic send(input logic [31:0] w, input string tag);
    @(negedge clk);
    in_word  = w;
    in_valid = 1'b1;
    exp_q.push_back({ref_fld(int'(w[31:22]), 5), ref_fld(int'(w[21:11]), 6),
                     ref_fld(int'(w[10:0]), 6)});
    tag_q.push_back(tag);
    n_sent++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_word  = 32'hFFFF_FFFF;
    end
  endtask

  function automatic logic [31:0] pack(input int r, input int g, input int b);
    return {10'(b), 11'(g), 11'(r)};
  endfunction

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        n_checks++;
        n_fail++;
        $display("FAIL R2 actual=out_valid expected=no result pending");
      end else begin
        logic [95:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        last_exp = e;
        n_recv++;
        check({t, " R3 red"},   out_red,   e[31:0]);
        check({t, " R3 green"}, out_green, e[63:32]);
        check({t, " R3 blue"},  out_blue,  e[95:64]);
        check("R8 alpha", out_alpha, 32'h3F80_0000);
        check("R9 sign", {29'b0, out_red[31], out_green[31], out_blue[31]}, 32'h0);
      end
    end
  end

  initial begin
    #4_000_000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(negedge clk);
    check("R1 reset valid", {31'b0, out_valid}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset valid", {31'b0, out_valid}, 32'h0);

    send(pack(15 << 6, 16 << 6, 14 << 5), "R4 unit values");
    idle(1);
    send(pack(0, 0, 0), "R6 zeros");
    send(pack(1, 63, 31), "R5 denorm low/full");
    send(pack(32, 16, 16), "R5 denorm top bit");
    send(pack(31 << 6, (31 << 6) | 1, (31 << 5) | 31), "R7 inf/nan");
    send(pack((30 << 6) | 63, 1 << 6, (30 << 5) | 31), "R4 extremes");
    send(pack(32, 0, 31 << 5), "R3 mixed classes");
    send(pack(0, 31 << 6, 1), "R3 mixed classes b");
    idle(1);

    // Idle window: outputs must hold and valid must drop (R10, R2)
    idle(3);
    check("R2 idle valid", {31'b0, out_valid}, 32'h0);
    check("R10 hold red",   out_red,   last_exp[31:0]);
    check("R10 hold green", out_green, last_exp[63:32]);
    check("R10 hold blue",  out_blue,  last_exp[95:64]);

    lfsr = 32'h1234_5678;
    for (int k = 0; k < 60; k++) begin
      lfsr = lfsr * 32'd1103515245 + 32'd12345;
      send(lfsr, "R2 stream");
    end
    idle(4);
    check("R2 result count", 32'(n_recv), 32'(n_sent));

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule